// File: doc/BRIEF.md
# Disk Controller Command Register Block

This block is the register front end of a single-drive moving-head disk controller. Software reaches it over a 16-bit bus that carries word writes, byte writes to either half of a word, word reads and a bus-wide reset. Most registers are plain storage that a separate transfer engine reads: word count, memory address, track/sector, cylinder and address extension. The primary control register is the active one. Each write to it is decoded into a function code and a start bit and dispatched as a housekeeping no-op, a seek, a read transfer or a write transfer.

A seek completes at once by copying the desired cylinder into the current cylinder. A transfer raises a level request to the transfer engine, which holds it until the engine pulses done. Completion of any operation can raise an interrupt request at a fixed bus level and vector. The request is held until the interrupt is acknowledged. The block models no seek or rotational timing and does no error checking beyond flagging an unknown function.

Top module: `disk_cmd_regs`

## Requirements
- R1: Byte-addressed registers answer at these offsets (octal): word count 02, memory address 04, track/sector 06, control 2 at 10, attention 16, lookahead 20, head offset 32, desired cylinder 34, current cylinder 36, address extension 50. Each reads back the last value written to it. The main control register is at 00 and drive status at 12.
- R2: Control register fields are start (GO) at bit 0, function at bits 5:1 (compared unshifted under mask 076), interrupt enable at bit 6, ready at bit 7, address bits 17:16 at bits 9:8, and transfer error at bit 14. A read of the control register always returns bit 7 set.
- R3: A control write with GO set stores the written value with the function field, GO and bit 14 cleared. All other bits are kept.
- R4: Function codes 06, 12, 16, 20 and 22 are no-ops, with or without GO. Each one sets ready and raises the interrupt request when interrupt enable is set.
- R5: Function 30 with GO is a seek. It loads current cylinder from desired cylinder and raises the interrupt request when enabled.
- R6: Function 60 with GO starts a write transfer (xfer_rd=0) and 70 with GO starts a read transfer (xfer_rd=1). xfer_req stays high until xfer_done. At done, the word count reads 0 and the interrupt request is raised if the stored enable bit is set.
- R7: A nonzero function written without GO, or function 0 with GO, starts nothing, raises no interrupt and leaves the current cylinder unchanged.
- R8: An unknown function written with GO sets bit 14 of drive status and raises no interrupt. The next recognised command written with GO clears it.
- R9: A byte write to the odd control address takes bus_wdata[15:8] into bits 15:8 only and decodes nothing. A byte write to the even address merges bus_wdata[7:0] into bits 7:0 and is decoded like a word write.
- R10: Drive status always reads with bits 6, 7, 8 and 12 set (mask 010700 octal).
- R11: irq_req, once raised, stays high until irq_ack is seen at a clock edge and then drops, unless a new event arrives in the same cycle. irq_level reads 5 and irq_vector reads 254 octal.
- R12: bus_init clears the control register to zero, drops the interrupt request and abandons any transfer in progress.
- R13: Control register writes that arrive while a transfer is pending are ignored.
- R14: The transfer address is {extension[5:0], memory address} when extension bits 5:0 are nonzero. Otherwise it is {control bits 9:8, memory address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_byte | input | 1 | Write is a single byte, with the lane chosen by bus_addr[0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| bus_init | input | 1 | Bus-wide reset |
| xfer_req | output | 1 | Transfer request to the transfer engine |
| xfer_rd | output | 1 | 1 = read transfer, 0 = write transfer |
| xfer_addr | output | 16+EXT_W | Physical memory address of the transfer |
| xfer_wc | output | 16 | Word count register |
| xfer_cyl | output | 16 | Desired cylinder |
| xfer_da | output | 16 | Desired track (15:8) and sector (7:0) |
| xfer_done | input | 1 | Transfer engine finished |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_level | output | 3 | Interrupt priority level |
| irq_vector | output | 9 | Interrupt vector |

## Verification
The bench targets the masking on a start write. A design that forgot to clear bit 14 or the function field would read back a stale error or a stale command. The byte lanes are tested in both directions. A design that decoded the odd half would start a seek from the high byte alone, and one that skipped decode on the even half would never move the current cylinder. A control write during a pending transfer must leave both the current cylinder and the stored control value unchanged. Without that rule a seek would be carried out in the middle of the transfer. The address extension is checked both set and clear, so that a wrong priority shows up as an address with the wrong upper bits. An unknown function must light the status bit without interrupting, and bus_init must drop both the interrupt and the transfer request.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int DW = 16;

    localparam logic [5:0] OFF_CS1 = 6'o00;
    localparam logic [5:0] OFF_WC  = 6'o02;
    localparam logic [5:0] OFF_BA  = 6'o04;
    localparam logic [5:0] OFF_DA  = 6'o06;
    localparam logic [5:0] OFF_CS2 = 6'o10;
    localparam logic [5:0] OFF_DS  = 6'o12;
    localparam logic [5:0] OFF_ATT = 6'o16;
    localparam logic [5:0] OFF_LA  = 6'o20;
    localparam logic [5:0] OFF_OFS = 6'o32;
    localparam logic [5:0] OFF_DC  = 6'o34;
    localparam logic [5:0] OFF_CC  = 6'o36;
    localparam logic [5:0] OFF_EXT = 6'o50;

    localparam int GO_BIT  = 0;
    localparam int IE_BIT  = 6;
    localparam int RDY_BIT = 7;
    localparam int ILL_BIT = 14;

    localparam logic [DW-1:0] FN_MASK  = 16'o000076;
    localparam logic [DW-1:0] GO_MASK  = 16'o000001;
    localparam logic [DW-1:0] TRE_MASK = 16'o040000;
    localparam logic [DW-1:0] RDY_MASK = 16'o000200;
    localparam logic [DW-1:0] DS_FORCE = 16'o010700;

    localparam logic [DW-1:0] FN_NOP_A = 16'o06;
    localparam logic [DW-1:0] FN_NOP_B = 16'o12;
    localparam logic [DW-1:0] FN_NOP_C = 16'o16;
    localparam logic [DW-1:0] FN_NOP_D = 16'o20;
    localparam logic [DW-1:0] FN_NOP_E = 16'o22;
    localparam logic [DW-1:0] FN_SEEK  = 16'o30;
    localparam logic [DW-1:0] FN_WRITE = 16'o60;
    localparam logic [DW-1:0] FN_READ  = 16'o70;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_NOP, ACT_SEEK, ACT_WRITE, ACT_READ, ACT_ILLEGAL
    } act_e;

    typedef struct packed {
        logic [DW-1:0] cs1;
        logic [DW-1:0] wc;
        logic [DW-1:0] ba;
        logic [DW-1:0] da;
        logic [DW-1:0] cs2;
        logic [DW-1:0] ds;
        logic [DW-1:0] att;
        logic [DW-1:0] la;
        logic [DW-1:0] ofs;
        logic [DW-1:0] dc;
        logic [DW-1:0] cc;
        logic [DW-1:0] ext;
        logic          busy;
        logic          rd;
        logic          illegal;
    } regs_t;
endpackage

// File: rtl/dcr_func_decode.sv
module dcr_func_decode
    import dcr_pkg::*;
(
    input  logic [DW-1:0] val,
    output act_e          act,
    output logic [DW-1:0] kept
);
    logic [DW-1:0] fn;
    logic          go;

    always_comb begin
        fn   = val & FN_MASK;
        go   = val[GO_BIT];
        kept = go ? (val & ~(FN_MASK | GO_MASK | TRE_MASK)) : val;
        act  = ACT_NONE;
        if (fn == '0) begin
            act = ACT_NONE;
        end else if (fn == FN_NOP_A || fn == FN_NOP_B || fn == FN_NOP_C ||
                     fn == FN_NOP_D || fn == FN_NOP_E) begin
            act = ACT_NOP;
        end else if (go) begin
            case (fn)
                FN_SEEK:  act = ACT_SEEK;
                FN_WRITE: act = ACT_WRITE;
                FN_READ:  act = ACT_READ;
                default:  act = ACT_ILLEGAL;
            endcase
        end
    end
endmodule

// File: rtl/dcr_irq.sv
module dcr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    input  logic clr,
    output logic req
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (ack)  req_d = 1'b0;
        if (fire) req_d = 1'b1;
        if (clr)  req_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;
endmodule

// File: rtl/dcr_addr_gen.sv
module dcr_addr_gen #(
    parameter int EXT_W = 6,
    localparam int PA_W = 16 + EXT_W
) (
    input  logic [15:0]     mem_addr,
    input  logic [1:0]      hi_bits,
    input  logic [15:0]     ext,
    output logic [PA_W-1:0] phys
);
    logic [EXT_W-1:0] ext_sel;

    always_comb begin
        ext_sel = ext[EXT_W-1:0];
        if (|ext_sel) phys = {ext_sel, mem_addr};
        else          phys = {{(EXT_W-2){1'b0}}, hi_bits, mem_addr};
    end
endmodule

// File: rtl/disk_cmd_regs.sv
module disk_cmd_regs
    import dcr_pkg::*;
#(
    parameter int          AW         = 6,
    parameter int          EXT_W      = 6,
    parameter logic [2:0]  IRQ_LEVEL  = 3'd5,
    parameter logic [8:0]  IRQ_VECTOR = 9'o254,
    localparam int         PA_W       = 16 + EXT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_byte,
    input  logic [15:0]     bus_wdata,
    output logic [15:0]     bus_rdata,
    input  logic            bus_init,
    output logic            xfer_req,
    output logic            xfer_rd,
    output logic [PA_W-1:0] xfer_addr,
    output logic [15:0]     xfer_wc,
    output logic [15:0]     xfer_cyl,
    output logic [15:0]     xfer_da,
    input  logic            xfer_done,
    output logic            irq_req,
    input  logic            irq_ack,
    output logic [2:0]      irq_level,
    output logic [8:0]      irq_vector
);
    regs_t         q, d;
    logic [AW-1:0] sel;
    logic          odd;
    logic          fire;
    logic [DW-1:0] cs1_cand;
    logic [DW-1:0] dec_kept;
    act_e          dec_act;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] wd,
                                            input logic by, input logic od);
        if (!by)     return wd;
        else if (od) return {wd[15:8], old[7:0]};
        else         return {old[15:8], wd[7:0]};
    endfunction

    assign sel      = {bus_addr[AW-1:1], 1'b0};
    assign odd      = bus_addr[0];
    assign cs1_cand = merge(q.cs1, bus_wdata, bus_byte, odd);

    dcr_func_decode u_dec (
        .val  (cs1_cand),
        .act  (dec_act),
        .kept (dec_kept)
    );

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (bus_wr) begin
            case (sel)
                AW'(OFF_CS1): begin
                    if (!q.busy) begin
                        if (bus_byte && odd) begin
                            d.cs1 = cs1_cand;
                        end else begin
                            d.cs1 = dec_kept;
                            case (dec_act)
                                ACT_NOP: begin
                                    d.cs1[RDY_BIT] = 1'b1;
                                    fire = dec_kept[IE_BIT];
                                    if (cs1_cand[GO_BIT]) d.illegal = 1'b0;
                                end
                                ACT_SEEK: begin
                                    d.cs1[RDY_BIT] = 1'b1;
                                    d.cc      = q.dc;
                                    fire      = dec_kept[IE_BIT];
                                    d.illegal = 1'b0;
                                end
                                ACT_WRITE, ACT_READ: begin
                                    d.busy    = 1'b1;
                                    d.rd      = (dec_act == ACT_READ);
                                    d.illegal = 1'b0;
                                end
                                ACT_ILLEGAL: d.illegal = 1'b1;
                                default: ;
                            endcase
                        end
                    end
                end
                AW'(OFF_WC):  d.wc  = merge(q.wc,  bus_wdata, bus_byte, odd);
                AW'(OFF_BA):  d.ba  = merge(q.ba,  bus_wdata, bus_byte, odd);
                AW'(OFF_DA):  d.da  = merge(q.da,  bus_wdata, bus_byte, odd);
                AW'(OFF_CS2): d.cs2 = merge(q.cs2, bus_wdata, bus_byte, odd);
                AW'(OFF_DS):  d.ds  = merge(q.ds,  bus_wdata, bus_byte, odd);
                AW'(OFF_ATT): d.att = merge(q.att, bus_wdata, bus_byte, odd);
                AW'(OFF_LA):  d.la  = merge(q.la,  bus_wdata, bus_byte, odd);
                AW'(OFF_OFS): d.ofs = merge(q.ofs, bus_wdata, bus_byte, odd);
                AW'(OFF_DC):  d.dc  = merge(q.dc,  bus_wdata, bus_byte, odd);
                AW'(OFF_CC):  d.cc  = merge(q.cc,  bus_wdata, bus_byte, odd);
                AW'(OFF_EXT): d.ext = merge(q.ext, bus_wdata, bus_byte, odd);
                default: ;
            endcase
        end
        if (q.busy && xfer_done) begin
            d.busy         = 1'b0;
            d.wc           = '0;
            d.cs1[RDY_BIT] = 1'b1;
            fire           = q.cs1[IE_BIT];
        end
        if (bus_init) begin
            d.cs1 = '0;
            d.busy = 1'b0;
            fire  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (sel)
            AW'(OFF_CS1): bus_rdata = q.cs1 | RDY_MASK;
            AW'(OFF_WC):  bus_rdata = q.wc;
            AW'(OFF_BA):  bus_rdata = q.ba;
            AW'(OFF_DA):  bus_rdata = q.da;
            AW'(OFF_CS2): bus_rdata = q.cs2;
            AW'(OFF_DS):  bus_rdata = q.ds | DS_FORCE | (DW'(q.illegal) << ILL_BIT);
            AW'(OFF_ATT): bus_rdata = q.att;
            AW'(OFF_LA):  bus_rdata = q.la;
            AW'(OFF_OFS): bus_rdata = q.ofs;
            AW'(OFF_DC):  bus_rdata = q.dc;
            AW'(OFF_CC):  bus_rdata = q.cc;
            AW'(OFF_EXT): bus_rdata = q.ext;
            default:      bus_rdata = '0;
        endcase
    end

    dcr_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .ack   (irq_ack),
        .clr   (bus_init),
        .req   (irq_req)
    );

    dcr_addr_gen #(.EXT_W(EXT_W)) u_addr (
        .mem_addr (q.ba),
        .hi_bits  (q.cs1[9:8]),
        .ext      (q.ext),
        .phys     (xfer_addr)
    );

    assign xfer_req   = q.busy;
    assign xfer_rd    = q.rd;
    assign xfer_wc    = q.wc;
    assign xfer_cyl   = q.dc;
    assign xfer_da    = q.da;
    assign irq_level  = IRQ_LEVEL;
    assign irq_vector = IRQ_VECTOR;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_byte,
    input logic          bus_init,
    input logic [15:0]   bus_rdata,
    input logic          xfer_req,
    input logic          xfer_rd,
    input logic          xfer_done,
    input logic          irq_req,
    input logic          irq_ack
);
    assert_cs1_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[AW-1:1] == '0) |-> bus_rdata[7]);

    assert_ds_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ({bus_addr[AW-1:1], 1'b0} == AW'(6'o12)) |-> ((bus_rdata & 16'o010700) == 16'o010700));

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !bus_init) |=> irq_req);

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(bus_wr || xfer_done));

    assert_xfer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done && !bus_init) |=> (xfer_req && $stable(xfer_rd)));

    assert_init_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> (!irq_req && !xfer_req));

    assert_hibyte_nodecode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_byte && bus_addr == AW'(1) && !xfer_req) |=> !xfer_req);
endmodule

bind disk_cmd_regs dcr_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte),
    .bus_init  (bus_init),
    .bus_rdata (bus_rdata),
    .xfer_req  (xfer_req),
    .xfer_rd   (xfer_rd),
    .xfer_done (xfer_done),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack)
);

// File: tb/disk_cmd_regs_tb.sv
module disk_cmd_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_init = 1'b0;
    logic        xfer_req, xfer_rd;
    logic [21:0] xfer_addr;
    logic [15:0] xfer_wc, xfer_cyl, xfer_da;
    logic        xfer_done = 1'b0;
    logic        irq_req;
    logic        irq_ack = 1'b0;
    logic [2:0]  irq_level;
    logic [8:0]  irq_vector;
    int total = 0;
    int bad = 0;
    bit fin = 0;

    always #2 clk = ~clk;

    disk_cmd_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_init(bus_init), .xfer_req(xfer_req), .xfer_rd(xfer_rd),
        .xfer_addr(xfer_addr), .xfer_wc(xfer_wc), .xfer_cyl(xfer_cyl),
        .xfer_da(xfer_da), .xfer_done(xfer_done), .irq_req(irq_req),
        .irq_ack(irq_ack), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0o expected=%0o", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] v, input logic by);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_byte = by; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic init_pulse();
        @(negedge clk); bus_init = 1'b1;
        @(negedge clk); bus_init = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(6'o00, v); chk("R2", "cs1 after reset", v, 16'o000200);
        rd(6'o12, v); chk("R10", "drive status forced", v, 16'o010700);
        chk("R11", "irq low after reset", irq_req, 0);
        chk("R11", "irq level", irq_level, 5);
        chk("R11", "irq vector", irq_vector, 9'o254);
        chk("R6", "no transfer after reset", xfer_req, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        logic [5:0] offs [11] = '{6'o02, 6'o04, 6'o06, 6'o10, 6'o16, 6'o20,
                                  6'o32, 6'o34, 6'o36, 6'o50, 6'o02};
        for (int i = 0; i < 10; i++) wr(offs[i], 16'h1000 + 16'(i * 16'o123), 1'b0);
        for (int i = 0; i < 10; i++) begin
            rd(offs[i], v);
            chk("R1", "register readback", v, 16'h1000 + 16'(i * 16'o123));
        end
        wr(6'o50, 16'h0000, 1'b0);
    endtask

    task automatic t_go_nop();
        logic [15:0] v;
        wr(6'o00, 16'o041107, 1'b0);
        rd(6'o00, v); chk("R3", "go clears fn/go/tre", v, 16'o001300);
        chk("R4", "nop with go raises irq", irq_req, 1);
        @(negedge clk);
        chk("R11", "irq held before ack", irq_req, 1);
        ack();
        chk("R11", "irq dropped after ack", irq_req, 0);
        wr(6'o00, 16'o000112, 1'b0);
        rd(6'o00, v); chk("R4", "nop without go stored", v, 16'o000312);
        chk("R4", "nop without go irq", irq_req, 1);
        ack();
        wr(6'o00, 16'o000022, 1'b0);
        chk("R4", "nop without enable no irq", irq_req, 0);
    endtask

    task automatic t_seek();
        logic [15:0] v;
        wr(6'o34, 16'o000123, 1'b0);
        wr(6'o36, 16'o000000, 1'b0);
        wr(6'o00, 16'o000131, 1'b0);
        rd(6'o36, v); chk("R5", "seek copies cylinder", v, 16'o000123);
        chk("R5", "seek irq", irq_req, 1);
        ack();
    endtask

    task automatic t_nogo();
        logic [15:0] v;
        wr(6'o36, 16'o11, 1'b0);
        wr(6'o34, 16'o22, 1'b0);
        wr(6'o00, 16'o000170, 1'b0);
        chk("R7", "read without go no transfer", xfer_req, 0);
        chk("R7", "read without go no irq", irq_req, 0);
        rd(6'o00, v); chk("R7", "read without go stored", v, 16'o000370);
        wr(6'o00, 16'o000130, 1'b0);
        rd(6'o36, v); chk("R7", "seek without go keeps cc", v, 16'o11);
        wr(6'o00, 16'o000101, 1'b0);
        chk("R7", "function 0 with go no irq", irq_req, 0);
        rd(6'o00, v); chk("R7", "function 0 with go stored", v, 16'o000300);
    endtask

    task automatic t_illegal();
        logic [15:0] v;
        wr(6'o00, 16'o000143, 1'b0);
        rd(6'o12, v); chk("R8", "illegal flag set", v, 16'o050700);
        chk("R8", "illegal no irq", irq_req, 0);
        wr(6'o00, 16'o000031, 1'b0);
        rd(6'o12, v); chk("R8", "illegal flag cleared", v, 16'o010700);
    endtask

    task automatic t_xfer();
        logic [15:0] v;
        wr(6'o02, 16'o177000, 1'b0);
        wr(6'o04, 16'o012344, 1'b0);
        wr(6'o50, 16'o0, 1'b0);
        wr(6'o34, 16'o55, 1'b0);
        wr(6'o36, 16'o0, 1'b0);
        wr(6'o00, 16'o001171, 1'b0);
        chk("R6", "read transfer requested", xfer_req, 1);
        chk("R6", "direction read", xfer_rd, 1);
        chk("R14", "address from control bits", xfer_addr, 22'(16'o012344) | (22'd1 << 17));
        chk("R6", "word count to engine", xfer_wc, 16'o177000);
        wr(6'o00, 16'o000131, 1'b0);
        rd(6'o36, v); chk("R13", "seek dropped while busy", v, 16'o0);
        rd(6'o00, v); chk("R13", "control unchanged while busy", v, 16'o001300);
        chk("R6", "no irq before done", irq_req, 0);
        done_pulse();
        chk("R6", "request dropped at done", xfer_req, 0);
        chk("R6", "irq at done", irq_req, 1);
        rd(6'o02, v); chk("R6", "word count zero after", v, 16'o0);
        ack();
        wr(6'o50, 16'o5, 1'b0);
        wr(6'o00, 16'o000461, 1'b0);
        chk("R6", "direction write", xfer_rd, 0);
        chk("R14", "address from extension", xfer_addr, (22'd5 << 16) | 22'(16'o012344));
        done_pulse();
        chk("R6", "no irq without enable", irq_req, 0);
        chk("R6", "write transfer ends", xfer_req, 0);
        wr(6'o50, 16'o0, 1'b0);
    endtask

    task automatic t_byte();
        logic [15:0] v;
        wr(6'o00, 16'o0, 1'b0);
        wr(6'o34, 16'o77, 1'b0);
        wr(6'o36, 16'o0, 1'b0);
        wr(6'o01, 16'h4159, 1'b1);
        rd(6'o00, v); chk("R9", "odd byte sets upper only", v, 16'h4180);
        rd(6'o36, v); chk("R9", "odd byte no decode", v, 16'o0);
        chk("R9", "odd byte no irq", irq_req, 0);
        wr(6'o00, 16'hFF59, 1'b1);
        rd(6'o00, v); chk("R9", "even byte merged and decoded", v, 16'h01C0);
        rd(6'o36, v); chk("R9", "even byte seek ran", v, 16'o77);
        chk("R9", "even byte irq", irq_req, 1);
        ack();
    endtask

    task automatic t_init();
        logic [15:0] v;
        wr(6'o00, 16'o000131, 1'b0);
        wr(6'o00, 16'o000171, 1'b0);
        chk("R12", "setup transfer pending", xfer_req, 1);
        init_pulse();
        rd(6'o00, v); chk("R12", "control cleared", v, 16'o000200);
        chk("R12", "irq dropped", irq_req, 0);
        chk("R12", "transfer abandoned", xfer_req, 0);
    endtask

    initial begin
        #400000;
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_go_nop();
        t_seek();
        t_nogo();
        t_illegal();
        t_xfer();
        t_byte();
        t_init();
        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule